// File: doc/BRIEF.md
# Exception Path Header Classifier

This block classifies one packet per transaction from its lookup result and builds the small metadata header that tells a slow-path processor why the packet was taken off the fast path. Each input transaction carries a 32-bit lookup word with the hit, local-delivery and drop flags, a 12-bit exception vector and a counter index. It also carries the received UDP destination port and the forwarding-key fields from the lookup: transmit UDP destination port, transmit UDP source port and transmit IPv4 destination address.

A fixed priority tree selects the outcome. A packet can be dropped, sent to the slow path with a 4-byte header, sent with a 12-byte header that carries an 8-byte forwarding key, or marked as fast path with no header. Both the input and the output use valid/ready. The result sits in one output register. That register holds its contents while the consumer stalls, and it accepts a new input in the same cycle that the current result is taken. `in_ready` is high whenever the register is empty or `out_ready` is high. Data changes only on an accepted transfer.

Top module: `exc_hdr_classifier`

## Requirements
- R1: Lookup word layout: bit 31 is reserved and ignored. Bit 30 is Hit, bit 29 is Local Delivery and bit 28 is Drop. Bits 27:16 are the exception vector, where bit 16 (vector bit 0) means TTL expired and bit 17 (vector bit 1) means IP options present. The other vector bits are ignored. Bits 15:0 are the counter index.
- R2: When Drop is set, `out_drop` is 1 and type, length, port, key and `out_fast` are all 0, whatever the other inputs are.
- R3: Without Drop and without Hit, the type has bit 4 (no route) set, plus bit 0 when TTL expired. Length is 4, and the port and key are 0.
- R4: With Hit and without Drop, the conditions are tested in this order: local delivery, then redirect, then TTL expired, then IP options. The first one true sets exactly one type bit: bit 2, bit 3, bit 0 or bit 1 respectively.
- R5: For local delivery and TTL-expired outcomes, length is 4, the received UDP destination port is copied to `out_rx_dport`, and the key is 0.
- R6: For redirect and IP-option outcomes, length is 12, the port is copied, and `out_key` = {tx UDP dst port, tx UDP src port, tx IP dst address}, with the destination port in the top 16 bits.
- R7: A packet counts as a redirect exactly when the received UDP destination port equals the transmit UDP source port.
- R8: A hit with none of the four conditions sets `out_fast` to 1, with type, length, port, key and `out_drop` all 0.
- R9: The counter index is passed unchanged to `out_cntr` for every outcome.
- R10: A result appears on the outputs in the cycle after its input is accepted. While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Block can accept input |
| in_lookup | input | 32 | Lookup word (flags, exception vector, counter index) |
| in_rx_dport | input | 16 | Received UDP destination port |
| in_tx_dport | input | 16 | Transmit UDP destination port |
| in_tx_sport | input | 16 | Transmit UDP source port |
| in_tx_daddr | input | 32 | Transmit IPv4 destination address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_type | output | 8 | Header type bits |
| out_len | output | 8 | Header length in bytes (0, 4 or 12) |
| out_rx_dport | output | 16 | Port field of header |
| out_key | output | 64 | Forwarding key (type-dependent data) |
| out_drop | output | 1 | Packet to be discarded |
| out_fast | output | 1 | Packet stays on the fast path |
| out_cntr | output | 16 | Counter index |

## Verification
Every classification is due exactly one cycle after its input is accepted: the input is driven on a falling edge, taken at the next rising edge, and the registered result is sampled on the falling edge after that. The sweep covers all 64 combinations of hit, local delivery, drop, TTL, IP-option and redirect, with the reserved and unused vector bits toggled. A stall phase holds `out_ready` low for several cycles with a new input pending. It checks that the held result does not change and that the pending input is taken only in the cycle when `out_ready` returns.

// File: rtl/exc_hdr_pkg.sv
package exc_hdr_pkg;
  typedef enum logic [2:0] {
    CL_DROP, CL_MISS, CL_LOCAL, CL_REDIR, CL_TTL, CL_OPT, CL_FAST
  } cls_e;

  // type bit positions seen by the slow-path consumer
  localparam int TB_TTL = 0;
  localparam int TB_OPT = 1;
  localparam int TB_LD  = 2;
  localparam int TB_RD  = 3;
  localparam int TB_NR  = 4;

  localparam int HDR_SHORT = 4;
  localparam int HDR_LONG  = 12;
endpackage

// File: rtl/exc_hdr_decode.sv
module exc_hdr_decode
  import exc_hdr_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              hit,
  input  logic              local_dl,
  input  logic              drop,
  input  logic              ttl_exp,
  input  logic              ip_opt,
  input  logic [PORT_W-1:0] rx_dport,
  input  logic [PORT_W-1:0] tx_sport,
  output cls_e              cls
);
  logic redirect;

  always_comb begin
    redirect = (rx_dport == tx_sport);
    if (drop)          cls = CL_DROP;
    else if (!hit)     cls = CL_MISS;
    else if (local_dl) cls = CL_LOCAL;
    else if (redirect) cls = CL_REDIR;
    else if (ttl_exp)  cls = CL_TTL;
    else if (ip_opt)   cls = CL_OPT;
    else               cls = CL_FAST;
  end
endmodule

// File: rtl/exc_hdr_format.sv
module exc_hdr_format
  import exc_hdr_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 8,
  parameter int LEN_W  = 8,
  localparam int KEY_W = 2*PORT_W + ADDR_W
) (
  input  cls_e              cls,
  input  logic              ttl_exp,
  input  logic [PORT_W-1:0] rx_dport,
  input  logic [PORT_W-1:0] tx_dport,
  input  logic [PORT_W-1:0] tx_sport,
  input  logic [ADDR_W-1:0] tx_daddr,
  output logic [TYPE_W-1:0] typ,
  output logic [LEN_W-1:0]  len,
  output logic [PORT_W-1:0] port,
  output logic [KEY_W-1:0]  key,
  output logic              drop_o,
  output logic              fast_o
);
  logic [KEY_W-1:0] fwd_key;
  assign fwd_key = {tx_dport, tx_sport, tx_daddr};

  always_comb begin
    typ    = '0;
    len    = '0;
    port   = '0;
    key    = '0;
    drop_o = 1'b0;
    fast_o = 1'b0;
    unique case (cls)
      CL_DROP: drop_o = 1'b1;
      CL_MISS: begin
        typ[TB_NR]  = 1'b1;
        typ[TB_TTL] = ttl_exp;
        len         = LEN_W'(HDR_SHORT);
      end
      CL_LOCAL: begin
        typ[TB_LD] = 1'b1;
        len        = LEN_W'(HDR_SHORT);
        port       = rx_dport;
      end
      CL_REDIR: begin
        typ[TB_RD] = 1'b1;
        len        = LEN_W'(HDR_LONG);
        port       = rx_dport;
        key        = fwd_key;
      end
      CL_TTL: begin
        typ[TB_TTL] = 1'b1;
        len         = LEN_W'(HDR_SHORT);
        port        = rx_dport;
      end
      CL_OPT: begin
        typ[TB_OPT] = 1'b1;
        len         = LEN_W'(HDR_LONG);
        port        = rx_dport;
        key         = fwd_key;
      end
      default: fast_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/exc_hdr_outreg.sv
module exc_hdr_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/exc_hdr_classifier.sv
module exc_hdr_classifier
  import exc_hdr_pkg::*;
#(
  parameter int EXC_W  = 12,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 8,
  parameter int LEN_W  = 8,
  localparam int LK_W  = 4 + EXC_W + CNT_W,
  localparam int KEY_W = 2*PORT_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LK_W-1:0]   in_lookup,
  input  logic [PORT_W-1:0] in_rx_dport,
  input  logic [PORT_W-1:0] in_tx_dport,
  input  logic [PORT_W-1:0] in_tx_sport,
  input  logic [ADDR_W-1:0] in_tx_daddr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TYPE_W-1:0] out_type,
  output logic [LEN_W-1:0]  out_len,
  output logic [PORT_W-1:0] out_rx_dport,
  output logic [KEY_W-1:0]  out_key,
  output logic              out_drop,
  output logic              out_fast,
  output logic [CNT_W-1:0]  out_cntr
);
  localparam int HIT_B  = LK_W - 2;
  localparam int LD_B   = LK_W - 3;
  localparam int DROP_B = LK_W - 4;
  localparam int EXC_LO = CNT_W;
  localparam int PAY_W  = TYPE_W + LEN_W + PORT_W + KEY_W + 2 + CNT_W;

  logic [EXC_W-1:0] exc_vec;
  logic [CNT_W-1:0] cntr;
  logic             unused_lk_bits;
  cls_e             cls;

  assign exc_vec        = in_lookup[EXC_LO +: EXC_W];
  assign cntr           = in_lookup[CNT_W-1:0];
  assign unused_lk_bits = in_lookup[LK_W-1] ^ (^exc_vec[EXC_W-1:2]);

  exc_hdr_decode #(.PORT_W(PORT_W)) u_decode (
    .hit      (in_lookup[HIT_B]),
    .local_dl (in_lookup[LD_B]),
    .drop     (in_lookup[DROP_B]),
    .ttl_exp  (exc_vec[0]),
    .ip_opt   (exc_vec[1]),
    .rx_dport (in_rx_dport),
    .tx_sport (in_tx_sport),
    .cls      (cls)
  );

  logic [TYPE_W-1:0] f_type;
  logic [LEN_W-1:0]  f_len;
  logic [PORT_W-1:0] f_port;
  logic [KEY_W-1:0]  f_key;
  logic              f_drop, f_fast;

  exc_hdr_format #(
    .PORT_W(PORT_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .LEN_W(LEN_W)
  ) u_format (
    .cls      (cls),
    .ttl_exp  (exc_vec[0]),
    .rx_dport (in_rx_dport),
    .tx_dport (in_tx_dport),
    .tx_sport (in_tx_sport),
    .tx_daddr (in_tx_daddr),
    .typ      (f_type),
    .len      (f_len),
    .port     (f_port),
    .key      (f_key),
    .drop_o   (f_drop),
    .fast_o   (f_fast)
  );

  logic [PAY_W-1:0] pay_in, pay_out;
  assign pay_in = {f_type, f_len, f_port, f_key, f_drop, f_fast, cntr};

  exc_hdr_outreg #(.W(PAY_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_type, out_len, out_rx_dport, out_key, out_drop, out_fast, out_cntr} = pay_out;
endmodule

// File: rtl/exc_hdr_classifier_chk.sv
module exc_hdr_classifier_chk #(
  parameter int PORT_W = 16,
  parameter int TYPE_W = 8,
  parameter int LEN_W  = 8,
  parameter int KEY_W  = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TYPE_W-1:0] out_type,
  input logic [LEN_W-1:0]  out_len,
  input logic [PORT_W-1:0] out_rx_dport,
  input logic [KEY_W-1:0]  out_key,
  input logic              out_drop,
  input logic              out_fast,
  input logic [CNT_W-1:0]  out_cntr
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_len)
      && $stable(out_rx_dport) && $stable(out_key) && $stable(out_drop)
      && $stable(out_fast) && $stable(out_cntr)));

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> (out_type == '0 && out_len == '0 && out_key == '0 && !out_fast));

  a_r8_fast_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fast) |-> (out_type == '0 && out_len == '0 && !out_drop));

  a_r4_single_hit_type: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_type[4]) |-> $onehot0(out_type));

  a_r6_long_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type[3] || out_type[1])) |-> (out_len == LEN_W'(12)));
endmodule

bind exc_hdr_classifier exc_hdr_classifier_chk #(
  .PORT_W(PORT_W), .TYPE_W(TYPE_W), .LEN_W(LEN_W), .KEY_W(KEY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_type(out_type), .out_len(out_len),
  .out_rx_dport(out_rx_dport), .out_key(out_key), .out_drop(out_drop),
  .out_fast(out_fast), .out_cntr(out_cntr)
);

// File: tb/exc_hdr_classifier_tb.sv
module exc_hdr_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_lookup = '0;
  logic [15:0] in_rx_dport = '0, in_tx_dport = '0, in_tx_sport = '0;
  logic [31:0] in_tx_daddr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_type, out_len;
  logic [15:0] out_rx_dport, out_cntr;
  logic [63:0] out_key;
  logic        out_drop, out_fast;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_hdr_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lookup(in_lookup), .in_rx_dport(in_rx_dport), .in_tx_dport(in_tx_dport),
    .in_tx_sport(in_tx_sport), .in_tx_daddr(in_tx_daddr), .out_valid(out_valid),
    .out_ready(out_ready), .out_type(out_type), .out_len(out_len),
    .out_rx_dport(out_rx_dport), .out_key(out_key), .out_drop(out_drop),
    .out_fast(out_fast), .out_cntr(out_cntr)
  );

  typedef struct {
    logic [7:0]  typ;
    logic [7:0]  len;
    logic [15:0] port;
    logic [63:0] key;
    logic        drop;
    logic        fast;
  } exp_t;

  exp_t cur;
  logic [15:0] cur_cntr;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected header from R2..R8; rd = rx port matches tx source port (R7)
  function automatic exp_t model(bit hit, bit ld, bit drp, bit ttl, bit opt, bit rd,
                                 logic [15:0] rx, logic [63:0] k);
    exp_t e;
    e.typ = 0; e.len = 0; e.port = 0; e.key = 0; e.drop = 0; e.fast = 0;
    if (drp) e.drop = 1;
    else if (!hit) begin e.typ = 8'h10 | {7'd0, ttl}; e.len = 4; end
    else if (ld)  begin e.typ = 8'h04; e.len = 4;  e.port = rx; end
    else if (rd)  begin e.typ = 8'h08; e.len = 12; e.port = rx; e.key = k; end
    else if (ttl) begin e.typ = 8'h01; e.len = 4;  e.port = rx; end
    else if (opt) begin e.typ = 8'h02; e.len = 12; e.port = rx; e.key = k; end
    else e.fast = 1;
    return e;
  endfunction

  // drive one input set at a falling edge; returns expected result
  task automatic drive(input int i);
    bit hit = i[0], ld = i[1], drp = i[2], ttl = i[3], opt = i[4], rd = i[5];
    logic [9:0]  junk = 10'(i * 37 + 5);
    logic [15:0] rx = 16'h1000 + 16'(i * 3);
    logic [15:0] txs = rd ? rx : (rx ^ 16'h0101);
    logic [15:0] txd = 16'hA000 + 16'(i);
    logic [31:0] da = 32'hC0A8_0000 + 32'(i * 257);
    in_lookup   = {i[0] ^ i[3], hit, ld, drp, junk, opt, ttl, 16'(i * 1000 + 7)};
    in_rx_dport = rx;
    in_tx_sport = txs;
    in_tx_dport = txd;
    in_tx_daddr = da;
    in_valid    = 1'b1;
    cur      = model(hit, ld, drp, ttl, opt, rd, rx, {txd, txs, da});
    cur_cntr = 16'(i * 1000 + 7);
  endtask

  task automatic check_out(input string tag);
    chk("R10", {tag, " valid"}, {63'd0, out_valid}, 64'd1);
    chk("R4",  {tag, " type"},  {56'd0, out_type}, {56'd0, cur.typ});
    chk("R5",  {tag, " len"},   {56'd0, out_len},  {56'd0, cur.len});
    chk("R5",  {tag, " port"},  {48'd0, out_rx_dport}, {48'd0, cur.port});
    chk("R6",  {tag, " key"},   out_key, cur.key);
    chk("R2",  {tag, " drop"},  {63'd0, out_drop}, {63'd0, cur.drop});
    chk("R8",  {tag, " fast"},  {63'd0, out_fast}, {63'd0, cur.fast});
    chk("R9",  {tag, " cntr"},  {48'd0, out_cntr}, {48'd0, cur_cntr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11", "reset ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R7: full sweep of the six deciding conditions
    for (int i = 0; i < 64; i++) begin
      drive(i);
      @(negedge clk);
      in_valid = 1'b0;
      check_out($sformatf("sweep%0d", i));
    end
    @(negedge clk);
    chk("R10", "idle valid", {63'd0, out_valid}, 64'd0);

    // R10 stall: hold a result while a new input waits
    out_ready = 1'b0;
    drive(45);
    @(negedge clk);
    check_out("stall first");
    drive(6);
    for (int s = 0; s < 3; s++) begin
      chk("R10", "stall in_ready", {63'd0, in_ready}, 64'd0);
      cur = model(1, 0, 1, 1, 0, 1, 16'h1000 + 16'(45 * 3), 64'd0);
      cur_cntr = 16'(45 * 1000 + 7);
      check_out("stall hold");
      @(negedge clk);
    end
    out_ready = 1'b1;
    drive(6);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("after stall");
    @(negedge clk);
    chk("R10", "drained", {63'd0, out_valid}, 64'd0);
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
  end

  initial begin
    wait (done || $time > 20000);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule